// File: doc/BRIEF.md
# Background Supply Measurement Monitor

This block schedules conversions of two supply channels, a battery voltage and an external DC input, on a single external ADC. A programmable interval timer makes both channels due at regular spacing, with no software action. Software can also make either channel due at once with a start strobe. Only one conversion is outstanding at a time. When both channels are waiting, the battery channel is served first.

Each finished conversion is stored in its channel's result register, and event pulses go to the interrupt controller. A battery result always raises a new-result pulse, and it also raises a low pulse when it is under the battery threshold. An external result always raises a ready pulse. It raises a delta pulse when it has moved far enough from the last value that raised a delta pulse.

Top module: `supply_meas_monitor`

## Requirements
- R1: After reset, `adc_req`, every event output and both result registers are 0.
- R2: With `cfg_interval` = N > 0 and the ADC idle, battery conversions begin exactly N cycles apart, and each one is followed by an external conversion.
- R3: With `cfg_interval` = 0, no conversion is requested unless a start strobe arrives.
- R4: A start strobe sampled at clock edge e while the block is idle raises `adc_req` after edge e+1, with `adc_chan` set to the strobed channel (0 = battery, 1 = external).
- R5: At most one conversion is outstanding. `adc_req` and `adc_chan` hold until `adc_done`, and `adc_req` drops after the edge that samples `adc_done`. A start strobe that arrives while busy is kept and served next.
- R6: When both channels are waiting, the battery channel (`adc_chan` = 0) is requested first.
- R7: On the edge after `adc_done` for the battery channel, `bat_result` holds `adc_data` and `bat_new_evt` pulses for one cycle.
- R8: `bat_low_evt` pulses together with `bat_new_evt` exactly when the stored result is strictly less than `bat_thresh`.
- R9: For an external result, `ext_delta_evt` pulses when |result − reference| > `ext_delta`. The reference starts at 0 and takes the new result only when this pulse fires.
- R10: On the edge after `adc_done` for the external channel, `ext_result` holds `adc_data` and `ext_ready` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_interval | input | IW | Cycles between scheduled rounds; 0 disables them |
| bat_thresh | input | DW | Battery low threshold |
| ext_delta | input | DW | External input change threshold |
| start_bat | input | 1 | One-cycle strobe: measure battery now |
| start_ext | input | 1 | One-cycle strobe: measure external input now |
| adc_req | output | 1 | Conversion request, held until done |
| adc_chan | output | 1 | Channel of the request: 0 battery, 1 external |
| adc_done | input | 1 | One-cycle completion from the ADC |
| adc_data | input | DW | Conversion result, valid with adc_done |
| bat_result | output | DW | Last battery result |
| ext_result | output | DW | Last external result |
| bat_new_evt | output | 1 | Pulse: new battery result stored |
| bat_low_evt | output | 1 | Pulse: stored battery result below threshold |
| ext_delta_evt | output | 1 | Pulse: external result moved beyond delta |
| ext_ready | output | 1 | Pulse: external result stored |

## Verification
Every result and event is registered once from `adc_done`. The bench waits for the ADC model's done pulse and samples these outputs one falling edge later. A start strobe needs two edges to reach `adc_req`, one for the pending flag and one for the launch, so the bench checks the request at the second falling edge after the strobe. For interval spacing, the bench stamps each battery completion with a cycle count and compares the difference against N, which removes any fixed pipeline offset. All samples are taken 1 ns after a falling edge.

// File: rtl/supply_meas_monitor.sv
module supply_meas_monitor #(
  parameter int DW = 10,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cfg_interval,
  input  logic [DW-1:0] bat_thresh,
  input  logic [DW-1:0] ext_delta,
  input  logic          start_bat,
  input  logic          start_ext,
  output logic          adc_req,
  output logic          adc_chan,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic [DW-1:0] bat_result,
  output logic [DW-1:0] ext_result,
  output logic          bat_new_evt,
  output logic          bat_low_evt,
  output logic          ext_delta_evt,
  output logic          ext_ready
);

  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] cnt;
  logic          tick, fin, launch;
  logic          pend_bat, pend_ext;
  logic [DW-1:0] ext_ref, ext_diff;

  assign tick     = (cfg_interval != '0) && (cnt == ONE);
  assign fin      = adc_req && adc_done;
  assign launch   = !adc_req && (pend_bat || pend_ext);
  assign ext_diff = (adc_data >= ext_ref) ? adc_data - ext_ref : ext_ref - adc_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt <= '0;
    else if (cfg_interval == '0)         cnt <= '0;
    else if (cnt == '0 || cnt == ONE)    cnt <= cfg_interval;
    else                                 cnt <= cnt - ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_bat <= 1'b0;
      pend_ext <= 1'b0;
    end else begin
      pend_bat <= (pend_bat && !launch) || start_bat || tick;
      pend_ext <= (pend_ext && !(launch && !pend_bat)) || start_ext || tick;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      adc_req  <= 1'b0;
      adc_chan <= 1'b0;
    end else if (fin) begin
      adc_req  <= 1'b0;
    end else if (launch) begin
      adc_req  <= 1'b1;
      adc_chan <= !pend_bat;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bat_result    <= '0;
      ext_result    <= '0;
      ext_ref       <= '0;
      bat_new_evt   <= 1'b0;
      bat_low_evt   <= 1'b0;
      ext_delta_evt <= 1'b0;
      ext_ready     <= 1'b0;
    end else begin
      bat_new_evt   <= fin && !adc_chan;
      bat_low_evt   <= fin && !adc_chan && (adc_data < bat_thresh);
      ext_ready     <= fin && adc_chan;
      ext_delta_evt <= fin && adc_chan && (ext_diff > ext_delta);
      if (fin && !adc_chan) bat_result <= adc_data;
      if (fin && adc_chan) begin
        ext_result <= adc_data;
        if (ext_diff > ext_delta) ext_ref <= adc_data;
      end
    end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_done |=> adc_req && $stable(adc_chan));

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !adc_req);

  assert_bat_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !adc_chan |=> bat_new_evt && bat_result == $past(adc_data));

  assert_low_with_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bat_low_evt |-> bat_new_evt);

  assert_delta_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_delta_evt |-> ext_ready);

  assert_ext_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin && adc_chan |=> ext_ready && ext_result == $past(adc_data));

endmodule

// File: tb/test_supply_meas_monitor.sv
module test_supply_meas_monitor;
  localparam int DW  = 6;
  localparam int IW  = 8;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic [IW-1:0] cfg_interval = '0;
  logic [DW-1:0] bat_thresh = '0, ext_delta = '0;
  logic start_bat = 0, start_ext = 0;
  logic adc_req, adc_chan, adc_done = 0;
  logic [DW-1:0] adc_data = '0;
  logic [DW-1:0] bat_result, ext_result;
  logic bat_new_evt, bat_low_evt, ext_delta_evt, ext_ready;

  int tests = 0, fails = 0, cyc = 0, lat = 0;
  logic [DW-1:0] mdl_bat = '0, mdl_ext = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  supply_meas_monitor #(.DW(DW), .IW(IW)) i_supply_meas_monitor (
    .clk, .rst_n, .cfg_interval, .bat_thresh, .ext_delta, .start_bat, .start_ext,
    .adc_req, .adc_chan, .adc_done, .adc_data, .bat_result, .ext_result,
    .bat_new_evt, .bat_low_evt, .ext_delta_evt, .ext_ready);

  always @(negedge clk) begin
    if (adc_done) adc_done = 0;
    else if (adc_req) begin
      if (lat == LAT) begin
        adc_done = 1;
        adc_data = adc_chan ? mdl_ext : mdl_bat;
        lat = 0;
      end else lat++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_n();
    @(negedge clk); #1;
  endtask

  task automatic wait_done(output logic ch, output int t);
    do tick_n(); while (!adc_done);
    ch = adc_chan;
    t = cyc;
    tick_n();
  endtask

  task automatic strobe(input bit b, input bit e);
    start_bat = b; start_ext = e;
    tick_n();
    start_bat = 0; start_ext = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog all actual=%0d expected=%0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ch;
    int t, tprev, rises;
    logic [DW-1:0] ref_v;
    repeat (3) tick_n();
    rst_n = 1;
    tick_n();
    // R1 reset state
    chk(!adc_req && !bat_new_evt && !bat_low_evt && !ext_delta_evt && !ext_ready,
        "R1 outputs", int'(adc_req), 0);
    chk(bat_result == 0 && ext_result == 0, "R1 results", int'(bat_result), 0);

    // R3 interval zero: idle
    rises = 0;
    repeat (100) begin tick_n(); if (adc_req) rises++; end
    chk(rises == 0, "R3 no requests", rises, 0);

    // R4 start timing
    mdl_bat = 6'd9;
    strobe(1, 0);
    chk(!adc_req, "R4 not yet after edge e", int'(adc_req), 0);
    tick_n();
    chk(adc_req && !adc_chan, "R4 request battery", int'(adc_req), 1);
    wait_done(ch, t);
    chk(bat_result == 9 && bat_new_evt, "R7 stored", int'(bat_result), 9);

    // R5 pending during busy, R6 priority
    mdl_ext = 6'd3;
    strobe(0, 1);
    tick_n();
    chk(adc_req && adc_chan, "R4 request external", int'(adc_chan), 1);
    strobe(1, 0);
    wait_done(ch, t);
    chk(ch == 1, "R5 first is external", int'(ch), 1);
    chk(!adc_req, "R5 request dropped", int'(adc_req), 0);
    wait_done(ch, t);
    chk(ch == 0, "R5 pending battery served", int'(ch), 0);
    strobe(1, 1);
    wait_done(ch, t);
    chk(ch == 0, "R6 battery first", int'(ch), 0);
    wait_done(ch, t);
    chk(ch == 1, "R6 external next", int'(ch), 1);
    tick_n();
    chk(!ext_ready && !bat_new_evt, "R10 single-cycle pulse", int'(ext_ready), 0);

    // R8 battery sweep
    bat_thresh = 6'd20;
    for (int v = 0; v < 64; v++) begin
      mdl_bat = v[DW-1:0];
      strobe(1, 0);
      wait_done(ch, t);
      chk(bat_result == v[DW-1:0] && bat_new_evt, "R7 battery result", int'(bat_result), v);
      chk(bat_low_evt == (v < 20), "R8 low event", int'(bat_low_evt), int'(v < 20));
    end

    // R9/R10 external sweeps; reference so far: 3 (0->3 with delta 0 fired)
    ext_delta = 6'd5;
    ref_v = 6'd3;
    for (int i = 0; i < 96; i++) begin
      logic [DW-1:0] v;
      int d;
      bit ev;
      v = (i < 48) ? DW'((i * 37) % 64) : DW'(30 + (i % 15) - 7);
      mdl_ext = v;
      strobe(0, 1);
      wait_done(ch, t);
      d = (int'(v) >= int'(ref_v)) ? int'(v) - int'(ref_v) : int'(ref_v) - int'(v);
      ev = d > 5;
      if (ev) ref_v = v;
      chk(ext_result == v && ext_ready, "R10 external result", int'(ext_result), int'(v));
      chk(ext_delta_evt == ev, "R9 delta event", int'(ext_delta_evt), int'(ev));
    end

    // R2 scheduled rounds
    mdl_bat = 6'd40; mdl_ext = 6'd41;
    cfg_interval = 8'd16;
    tprev = -1;
    for (int k = 0; k < 10; k++) begin
      wait_done(ch, t);
      chk(ch == (k % 2), "R2 battery then external", int'(ch), k % 2);
      if (ch == 0) begin
        if (tprev >= 0) chk(t - tprev == 16, "R2 spacing", t - tprev, 16);
        tprev = t;
      end
    end
    cfg_interval = '0;
    repeat (40) tick_n();
    rises = 0;
    repeat (200) begin tick_n(); if (adc_req) rises++; end
    chk(rises == 0, "R3 disabled after use", rises, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule